// File: doc/BRIEF.md
# Eight-bit ALU with Registered Condition Flags

This block is the arithmetic and logic stage of a small eight-bit processor datapath. On each cycle that `in_valid` is high, it takes an operation code, a register operand and a memory operand. It computes the result from those inputs and from its own held flags. One clock later it presents the result, a write-back enable and the updated Negative, Zero, Carry and oVerflow flags, all from registers.

Arithmetic is pure binary. In subtraction and comparison, carry acts as an inverted borrow. Overflow follows the signed-sign rule. The block keeps the four flags between operations, so a chain of add-with-carry or subtract-with-borrow operations works across bytes. Branch logic elsewhere reads the flag outputs.

Operand fetch, register storage and branching are handled outside this block. The block reports only the result, the write-back decision and the flags.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs `out_valid`, `out_result`, `out_wb`, N, Z, C and V are all cleared at that edge.
- R2: Op code 0 (add) gives result = reg + mem + C modulo 256. C becomes the carry out of bit 7. V is set when reg and mem have equal sign bits and the result sign differs from them.
- R3: Op code 1 (subtract) gives result = reg − mem − (1 − C) modulo 256. C is set when no borrow occurred. V is set when reg and the bitwise inverse of mem have equal sign bits and the result sign differs from them.
- R4: For every operation that asserts `out_wb`, N equals bit 7 of `out_result`, and Z is set exactly when `out_result` is zero.
- R5: Op codes 2, 3 and 4 give reg AND mem, reg OR mem and reg XOR mem. These operations leave C and V unchanged.
- R6: Op code 5 (compare) sets C when reg ≥ mem (unsigned), sets Z when reg = mem, and sets N from bit 7 of (reg − mem) modulo 256. It leaves V unchanged, drives `out_wb` low and returns reg as the result.
- R7: Op code 6 returns reg + 1 and op code 7 returns reg − 1, both modulo 256. These operations leave C and V unchanged.
- R8: Op code 8 shifts reg left, moving bit 7 into C and filling bit 0 with 0. Op code 9 shifts reg right, moving bit 0 into C and filling bit 7 with 0. Both leave V unchanged.
- R9: Op code 10 rotates reg left through carry: the old C enters bit 0 and the old bit 7 goes to C. Op code 11 rotates reg right through carry: the old C enters bit 7 and the old bit 0 goes to C. Both leave V unchanged.
- R10: Op codes 12 to 15 drive `out_wb` low, return reg as the result and leave all four flags unchanged.
- R11: A cycle with `in_valid` low produces `out_valid` low at the next edge and leaves all four flags unchanged.
- R12: The outputs for an operation accepted at one edge appear at the next edge, with `out_valid` high.

Op codes are the 4-bit unsigned values of `in_op`. With `out_wb` asserted, every op code from 0 to 11 except 5 writes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Operation code |
| in_reg | input | W (8) | Register (accumulator or index) operand |
| in_mem | input | W (8) | Memory operand |
| out_valid | output | 1 | Result registers hold a new operation |
| out_result | output | W (8) | Result value |
| out_wb | output | 1 | Result should be written back |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_c | output | 1 | Carry flag |
| out_v | output | 1 | Overflow flag |

## Verification
The only hidden state in this block is the flag register. A wrong carry value does not show on the C output alone. It also shows one operation later, in the result of the next add, subtract or rotate, because that carry feeds into it. For this reason the scoreboard keeps its own flag model and checks every operation. A flag that was wrongly changed by a logic, increment, compare or undefined operation is then detected either at the next output cycle or at the first later operation that consumes it.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_CMP  = 4'd5,
    OP_INC  = 4'd6,
    OP_DEC  = 4'd7,
    OP_SHL  = 4'd8,
    OP_SHR  = 4'd9,
    OP_ROTL = 4'd10,
    OP_ROTR = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  always_comb begin
    b_eff = sub ? ~b : b;
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    sum   = full[W-1:0];
    cout  = full[W];
    ovf   = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic            cin,
  output logic [W-1:0]    res,
  output logic            cout
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    res  = a;
    cout = cin;
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_INC:  res = a + ONE;
      OP_DEC:  res = a - ONE;
      OP_SHL:  begin res = {a[W-2:0], 1'b0}; cout = a[W-1]; end
      OP_SHR:  begin res = {1'b0, a[W-1:1]}; cout = a[0];   end
      OP_ROTL: begin res = {a[W-2:0], cin};  cout = a[W-1]; end
      OP_ROTR: begin res = {cin, a[W-1:1]};  cout = a[0];   end
      default: begin res = a; cout = cin; end
    endcase
  end
endmodule

// File: rtl/alu8_nz.sv
module alu8_nz #(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  output logic         neg,
  output logic         zero
);
  logic [W:0] any_set;

  assign any_set[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_or
    assign any_set[i+1] = any_set[i] | val[i];
  end

  assign neg  = val[W-1];
  assign zero = ~any_set[W];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [OP_W-1:0] in_op,
  input  logic [W-1:0]    in_reg,
  input  logic [W-1:0]    in_mem,
  output logic            out_valid,
  output logic [W-1:0]    out_result,
  output logic            out_wb,
  output logic            out_n,
  output logic            out_z,
  output logic            out_c,
  output logic            out_v
);
  alu_flags_t flags_q, flags_d;
  logic [W-1:0] res_d;
  logic         wb_d;

  logic         as_sub, as_cin, as_cout, as_ovf;
  logic [W-1:0] as_sum;
  logic [W-1:0] bo_res;
  logic         bo_cout;
  logic         r_neg, r_zero, d_neg, d_zero;

  always_comb begin
    as_sub = (in_op == OP_SUB) || (in_op == OP_CMP);
    as_cin = (in_op == OP_CMP) ? 1'b1 : flags_q.c;
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a(in_reg), .b(in_mem), .sub(as_sub), .cin(as_cin),
    .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
  );

  alu8_bitops #(.W(W)) u_bitops (
    .op(in_op), .a(in_reg), .b(in_mem), .cin(flags_q.c),
    .res(bo_res), .cout(bo_cout)
  );

  alu8_nz #(.W(W)) u_nz_res (.val(res_d),  .neg(r_neg), .zero(r_zero));
  alu8_nz #(.W(W)) u_nz_dif (.val(as_sum), .neg(d_neg), .zero(d_zero));

  always_comb begin
    res_d   = in_reg;
    wb_d    = 1'b0;
    flags_d = flags_q;
    case (in_op)
      OP_ADD, OP_SUB: begin
        res_d     = as_sum;
        wb_d      = 1'b1;
        flags_d.c = as_cout;
        flags_d.v = as_ovf;
      end
      OP_CMP: begin
        flags_d.n = d_neg;
        flags_d.z = d_zero;
        flags_d.c = as_cout;
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
        res_d = bo_res;
        wb_d  = 1'b1;
      end
      OP_SHL, OP_SHR, OP_ROTL, OP_ROTR: begin
        res_d     = bo_res;
        wb_d      = 1'b1;
        flags_d.c = bo_cout;
      end
      default: begin
        res_d = in_reg;
        wb_d  = 1'b0;
      end
    endcase
    if (wb_d) begin
      flags_d.n = r_neg;
      flags_d.z = r_zero;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q    <= '0;
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wb     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        flags_q    <= flags_d;
        out_result <= res_d;
        out_wb     <= wb_d;
      end
    end
  end

  assign out_n = flags_q.n;
  assign out_z = flags_q.z;
  assign out_c = flags_q.c;
  assign out_v = flags_q.v;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [3:0]   in_op,
  input logic         out_valid,
  input logic [W-1:0] out_result,
  input logic         out_wb,
  input logic         out_n,
  input logic         out_z,
  input logic         out_c,
  input logic         out_v
);
  p_latency_r12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_flags_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_n) && $stable(out_z)
                   && $stable(out_c) && $stable(out_v)));

  p_nz_match_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_wb) |-> (out_n == out_result[W-1]
                               && out_z == (out_result == '0)));

  p_cmp_no_wb_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'd5) |=> (!out_wb && $stable(out_v)));

  p_logic_cv_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_op == 4'd2 || in_op == 4'd3 || in_op == 4'd4))
      |=> ($stable(out_c) && $stable(out_v)));

  p_incdec_cv_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_op == 4'd6 || in_op == 4'd7))
      |=> ($stable(out_c) && $stable(out_v)));

  p_undef_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op >= 4'd12) |=> (!out_wb && $stable(out_n)
      && $stable(out_z) && $stable(out_c) && $stable(out_v)));
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
  .out_valid(out_valid), .out_result(out_result), .out_wb(out_wb),
  .out_n(out_n), .out_z(out_z), .out_c(out_c), .out_v(out_v)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [3:0]   in_op = '0;
  logic [W-1:0] in_reg = '0, in_mem = '0;
  logic         out_valid, out_wb, out_n, out_z, out_c, out_v;
  logic [W-1:0] out_result;

  int checks = 0;
  int fails  = 0;
  bit mn = 0, mz = 0, mc = 0, mv = 0;
  logic [12:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  alu8_core #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_reg(in_reg), .in_mem(in_mem), .out_valid(out_valid),
    .out_result(out_result), .out_wb(out_wb), .out_n(out_n),
    .out_z(out_z), .out_c(out_c), .out_v(out_v)
  );

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got res=%02h wb=%0b nzcv=%04b, expected res=%02h wb=%0b nzcv=%04b",
               req, act[12:5], act[4], act[3:0], exp[12:5], exp[4], exp[3:0]);
    end
  endtask

  // Independent reference model of one operation; updates model flags.
  task automatic send(input int op, input int r, input int m, input string req);
    int s;
    int res;
    bit wb;
    bit [7:0] mi;
    res = r;
    wb  = 1;
    case (op)
      0: begin s = r + m + mc; res = s & 255; mc = (s > 255);
               mv = (r[7] == m[7]) && (res[7] != r[7]); end
      1: begin s = r - m - (1 - mc); res = s & 255; mc = (s >= 0);
               mi = ~m[7:0]; mv = (r[7] == mi[7]) && (res[7] != r[7]); end
      2: res = r & m;
      3: res = r | m;
      4: res = r ^ m;
      5: begin wb = 0; mc = (r >= m); mz = (r == m); mn = (((r - m) & 255) >> 7) != 0; end
      6: res = (r + 1) & 255;
      7: res = (r + 255) & 255;
      8: begin mc = r[7]; res = (r << 1) & 255; end
      9: begin mc = r[0]; res = r >> 1; end
      10: begin s = mc; mc = r[7]; res = ((r << 1) & 255) | s; end
      11: begin s = mc; mc = r[0]; res = (r >> 1) | (s << 7); end
      default: wb = 0;
    endcase
    if (wb) begin
      mn = res[7];
      mz = (res == 0);
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op[3:0];
    in_reg   = r[7:0];
    in_mem   = m[7:0];
    exp_q.push_back({res[7:0], wb, mn, mz, mc, mv});
    tag_q.push_back(req);
  endtask

  task automatic idle_check();
    @(negedge clk);
    in_valid = 1'b0;
    in_op    = 4'd8;
    in_reg   = 8'hFF;
    @(negedge clk);
    check("R11", {out_result, out_valid, out_n, out_z, out_c, out_v},
                 {out_result, 1'b0, mn, mz, mc, mv});
  endtask

  // Monitor: pops expectations as results appear.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R12", 13'h1FFF, 13'h0);
      end else begin
        check(tag_q.pop_front(), {out_result, out_wb, out_n, out_z, out_c, out_v},
              exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {out_result, out_wb, out_n, out_z, out_c, out_v},
                {8'h00, out_valid, 4'b0000});
    rst = 1'b0;
    // R2 add
    send(0, 8'h10, 8'h20, "R2 add plain");
    send(0, 8'h50, 8'h50, "R2 add signed overflow");
    send(0, 8'hFF, 8'h01, "R2 add carry out zero");
    send(0, 8'h01, 8'h01, "R2 add with carry in");
    // R3 subtract
    send(1, 8'h05, 8'h03, "R3 sub borrow in");
    send(1, 8'h03, 8'h05, "R3 sub borrow out");
    send(1, 8'h80, 8'h01, "R3 sub signed overflow");
    // R5 logic
    send(2, 8'hF0, 8'h3C, "R5 and");
    send(3, 8'h00, 8'h00, "R5 or zero");
    send(4, 8'hAA, 8'h55, "R5 xor");
    // R6 compare
    send(5, 8'h40, 8'h40, "R6 cmp equal");
    send(5, 8'h10, 8'h20, "R6 cmp less");
    send(5, 8'h90, 8'h10, "R6 cmp greater");
    // R7 inc/dec wrap
    send(6, 8'hFF, 8'h00, "R7 inc wrap");
    send(7, 8'h00, 8'h00, "R7 dec wrap");
    // R8 shifts
    send(8, 8'h81, 8'h00, "R8 shl");
    send(9, 8'h01, 8'h00, "R8 shr to zero");
    // R9 rotates through carry
    send(10, 8'h80, 8'h00, "R9 rotl");
    send(10, 8'h01, 8'h00, "R9 rotl carry in");
    send(11, 8'h01, 8'h00, "R9 rotr");
    send(11, 8'h00, 8'h00, "R9 rotr carry in");
    // R10 undefined codes
    send(13, 8'h00, 8'h00, "R10 undefined");
    send(15, 8'h7E, 8'h01, "R10 undefined high");
    // R11 idle then flags still used (R4 checked on every write-back)
    idle_check();
    send(0, 8'h7F, 8'h00, "R4 add after idle");
    idle_check();
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R12", 13'h0, 13'h1FFF);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule